// File: doc/BRIEF.md
# MMC Command Line Controller

This block owns the command wire of a MultiMediaCard bus. A host writes one command at a time through a set of parallel fields: a 6-bit index, a 32-bit argument, a 2-bit reply kind and a drive-mode bit. The block builds the 48-bit command frame, protects it with a CRC7, and clocks it out one bit per card-clock period. It then listens on the same wire for the card's reply, which is either a short 48-bit frame or a long 136-bit frame, and stores the payload in four 32-bit words. At the end of the transaction it raises a one-cycle `done` strobe and reports a timeout or a CRC mismatch.

The card clock is made from the system clock by a programmable divider. While no command is in flight, an optional power-saving mode slows the card clock further by a power-of-two factor. Each command selects push/pull drive or open-drain drive on its own. In open-drain mode the block only ever pulls the wire low. A whole transaction runs on the system clock, and single-cycle strobes mark the card-clock edges.

Top module: `mmc_cmd_engine`

## Requirements
- R1: After reset and while `enable` is 0, the block ignores `cmd_valid`. `busy`, `done`, `cmd_oe` and `mmc_clk` stay 0, and `timeout`, `crc_err` and all response words read 0 after reset.
- R2: With `enable` = 1 and power saving off, each half period of `mmc_clk` lasts `clk_div`+1 system cycles.
- R3: With `pws_en` = 1 and no command in flight (`busy` = 0), each half period lasts (`clk_div`+1)·2^(`pws_div`+1) system cycles. While `busy` = 1 the rate of R2 applies.
- R4: A command goes out MSB first as 48 bits: bit 47 = 0 (start), bit 46 = 1, bits 45:40 = index, bits 39:8 = argument, bits 7:1 = CRC7, bit 0 = 1. Each bit changes on a rising edge of `mmc_clk` and is held for one full card period.
- R5: The CRC7 uses the polynomial x^7+x^3+1 with a zero start value over frame bits 47:8. For index 0 with argument 0, the last frame byte is 0x95.
- R6: With `cmd_od` = 1, the block never drives the wire high: `cmd_oe`=1 only with `cmd_out`=0, for 0 bits. With `cmd_od` = 0, `cmd_oe` = 1 for all 48 bits. In both modes the wire is released (`cmd_oe` = 0) one card period after the end bit starts.
- R7: `rsp_kind` encodes the reply: 0 = none, 1 = 48-bit, 2 = 136-bit, 3 = none. With no reply, `done` follows the end bit and `timeout` stays 0.
- R8: `cmd_in` is sampled on rising edges of `mmc_clk`. A reply start bit (0) is accepted on the 2nd through the 65th rising edge after the edge that drove the end bit. If none arrives, `timeout` is 1 when the command completes.
- R9: For a 48-bit reply, `rsp_w0` holds reply bits 39:8 and `rsp_w1`..`rsp_w3` read 0. `crc_err` is 1 exactly when reply bits 7:1 differ from the CRC7 of reply bits 47:8.
- R10: For a 136-bit reply, {`rsp_w3`,`rsp_w2`,`rsp_w1`,`rsp_w0`} holds the last 128 received bits with `rsp_w3` most significant, and `crc_err` is 0.
- R11: `done` is high for exactly one system cycle per command. The status and response outputs are valid from the next cycle until the next command is accepted. Accepting a command clears `timeout` and `crc_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 parks the block and the card clock |
| clk_div | input | 8 | Card clock half-period minus one, in system cycles |
| pws_en | input | 1 | Power-saving divide while idle |
| pws_div | input | 3 | Power-saving exponent; idle divide is 2^(pws_div+1) |
| cmd_valid | input | 1 | Start a command (taken while idle and enabled) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | Reply kind: 0 none, 1 short, 2 long, 3 none |
| cmd_od | input | 1 | 1 = open-drain drive for this command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| timeout | output | 1 | No reply start bit within the window |
| crc_err | output | 1 | Short reply failed its CRC7 check |
| rsp_w0 | output | 32 | Response word 0 (least significant) |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 (most significant) |
| mmc_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command wire output value |
| cmd_oe | output | 1 | Command wire drive enable |
| cmd_in | input | 1 | Command wire input value |

## Verification
Assertions check the following on every cycle:
- Disabling the block parks both the card clock and the sequencer with the wire released.
- A rise strobe is always followed by a high card clock.
- `done` never lasts longer than one cycle.
- A timeout can only come out of the reply wait.
- The wire is free while the sequencer waits for a reply.
- A long reply never reports a CRC error.

Some behaviours can only be shown through the bench's scenarios: the bit-exact frame and its CRC, the idle and busy clock periods, and open-drain versus push/pull drive seen from the wire. The same holds for the first and last accepted reply start positions, the timeout one edge later, and the placement of short and long reply payloads.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

  localparam int FRAME_LEN = 48;
  localparam int SHORT_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int KEEP_LEN  = 128;

  localparam logic [1:0] RSP_NONE  = 2'd0;
  localparam logic [1:0] RSP_SHORT = 2'd1;
  localparam logic [1:0] RSP_LONG  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_TAIL,
    ST_WAIT,
    ST_RECV,
    ST_DONE
  } seq_state_e;

  // CRC7, polynomial x^7 + x^3 + 1, zero start, 40 message bits MSB first
  function automatic logic [6:0] crc7_40(input logic [39:0] msg);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = msg[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/mmc_clkgen.sv
module mmc_clkgen #(
  parameter int DIV_W = 8,
  parameter int PWS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bus_idle,
  input  logic             pws_en,
  input  logic [PWS_W-1:0] pws_div,
  input  logic [DIV_W-1:0] clk_div,
  output logic             card_clk,
  output logic             rise_tick
);

  localparam int CNT_W = DIV_W + (1 << PWS_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base, limit;
  logic [PWS_W:0]   sh_amt;
  logic             clk_q, clk_d, wrap;

  always_comb begin
    base   = CNT_W'(clk_div) + CNT_W'(1);
    sh_amt = {1'b0, pws_div} + (PWS_W+1)'(1);
    if (pws_en && bus_idle) limit = (base << sh_amt) - CNT_W'(1);
    else                    limit = base - CNT_W'(1);
    wrap  = (cnt_q >= limit);
    cnt_d = cnt_q;
    clk_d = clk_q;
    if (!enable) begin
      cnt_d = '0;
      clk_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      clk_d = ~clk_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign card_clk  = clk_q;
  assign rise_tick = enable && wrap && !clk_q;

  a_r1_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !card_clk);

  a_r2_rise_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> card_clk);

endmodule

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq
  import mmc_cmd_pkg::*;
#(
  parameter int NCR_MAX = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        rise_tick,
  input  logic        cmd_valid,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  rsp_kind,
  input  logic        cmd_od,
  input  logic        cmd_in,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        shift_en,
  output logic        cap_clr,
  output logic        cap_latch,
  output logic        long_sel
);

  localparam int WC_W = $clog2(NCR_MAX);
  localparam int RC_W = $clog2(LONG_LEN + 1);

  seq_state_e             st_q, st_d;
  logic [FRAME_LEN-1:0]   frame_q, frame_d;
  logic [5:0]             idx_q, idx_d;
  logic                   od_q, od_d;
  logic [1:0]             kind_q, kind_d;
  logic                   drv_bit_q, drv_bit_d;
  logic                   drv_on_q, drv_on_d;
  logic [WC_W-1:0]        wcnt_q, wcnt_d;
  logic [RC_W-1:0]        rcnt_q, rcnt_d, rlast;
  logic                   to_q, to_d;
  logic                   has_rsp;
  logic [39:0]            head;

  assign has_rsp = (kind_q == RSP_SHORT) || (kind_q == RSP_LONG);
  assign rlast   = (kind_q == RSP_LONG) ? RC_W'(LONG_LEN - 1) : RC_W'(SHORT_LEN - 1);
  assign head    = {2'b01, cmd_index, cmd_arg};

  always_comb begin
    st_d      = st_q;
    frame_d   = frame_q;
    idx_d     = idx_q;
    od_d      = od_q;
    kind_d    = kind_q;
    drv_bit_d = drv_bit_q;
    drv_on_d  = drv_on_q;
    wcnt_d    = wcnt_q;
    rcnt_d    = rcnt_q;
    to_d      = to_q;
    cap_clr   = 1'b0;
    shift_en  = 1'b0;
    cap_latch = 1'b0;
    if (!enable) begin
      st_d     = ST_IDLE;
      drv_on_d = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (cmd_valid) begin
          cap_clr = 1'b1;
          frame_d = {head, crc7_40(head), 1'b1};
          idx_d   = 6'(FRAME_LEN - 1);
          od_d    = cmd_od;
          kind_d  = rsp_kind;
          to_d    = 1'b0;
          st_d    = ST_SEND;
        end
        ST_SEND: if (rise_tick) begin
          drv_on_d  = 1'b1;
          drv_bit_d = frame_q[idx_q];
          if (idx_q == 6'd0) st_d = ST_TAIL;
          else               idx_d = idx_q - 6'd1;
        end
        ST_TAIL: if (rise_tick) begin
          drv_on_d  = 1'b0;
          drv_bit_d = 1'b1;
          wcnt_d    = '0;
          st_d      = has_rsp ? ST_WAIT : ST_DONE;
        end
        ST_WAIT: if (rise_tick) begin
          if (!cmd_in) begin
            shift_en = 1'b1;
            rcnt_d   = RC_W'(1);
            st_d     = ST_RECV;
          end else if (wcnt_q == WC_W'(NCR_MAX - 1)) begin
            to_d = 1'b1;
            st_d = ST_DONE;
          end else begin
            wcnt_d = wcnt_q + WC_W'(1);
          end
        end
        ST_RECV: if (rise_tick) begin
          shift_en = 1'b1;
          rcnt_d   = rcnt_q + RC_W'(1);
          if (rcnt_q == rlast) st_d = ST_DONE;
        end
        ST_DONE: begin
          cap_latch = has_rsp && !to_q;
          st_d      = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      frame_q   <= '0;
      idx_q     <= '0;
      od_q      <= 1'b0;
      kind_q    <= RSP_NONE;
      drv_bit_q <= 1'b1;
      drv_on_q  <= 1'b0;
      wcnt_q    <= '0;
      rcnt_q    <= '0;
      to_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      frame_q   <= frame_d;
      idx_q     <= idx_d;
      od_q      <= od_d;
      kind_q    <= kind_d;
      drv_bit_q <= drv_bit_d;
      drv_on_q  <= drv_on_d;
      wcnt_q    <= wcnt_d;
      rcnt_q    <= rcnt_d;
      to_q      <= to_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign timeout  = to_q;
  assign long_sel = (kind_q == RSP_LONG);
  assign cmd_out  = od_q ? 1'b0 : drv_bit_q;
  assign cmd_oe   = drv_on_q && (od_q ? !drv_bit_q : 1'b1);

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !cmd_oe));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_timeout_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> ($past(st_q) == ST_WAIT));

  a_r6_free_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !cmd_oe);

endmodule

// File: rtl/mmc_rsp_capture.sv
module mmc_rsp_capture
  import mmc_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_en,
  input  logic        bit_in,
  input  logic        clr,
  input  logic        latch,
  input  logic        long_sel,
  output logic [31:0] w0,
  output logic [31:0] w1,
  output logic [31:0] w2,
  output logic [31:0] w3,
  output logic        crc_err
);

  logic [KEEP_LEN-1:0] sh_q, sh_d;
  logic [31:0]         w0_d, w1_d, w2_d, w3_d;
  logic                crc_d, crc_bad;

  assign crc_bad = (crc7_40(sh_q[SHORT_LEN-1:8]) != sh_q[7:1]);

  always_comb begin
    sh_d  = sh_q;
    w0_d  = w0;
    w1_d  = w1;
    w2_d  = w2;
    w3_d  = w3;
    crc_d = crc_err;
    if (shift_en) sh_d = {sh_q[KEEP_LEN-2:0], bit_in};
    if (latch) begin
      if (long_sel) begin
        w0_d  = sh_q[31:0];
        w1_d  = sh_q[63:32];
        w2_d  = sh_q[95:64];
        w3_d  = sh_q[127:96];
        crc_d = 1'b0;
      end else begin
        w0_d  = sh_q[39:8];
        w1_d  = '0;
        w2_d  = '0;
        w3_d  = '0;
        crc_d = crc_bad;
      end
    end else if (clr) begin
      crc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      w0      <= '0;
      w1      <= '0;
      w2      <= '0;
      w3      <= '0;
      crc_err <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      w0      <= w0_d;
      w1      <= w1_d;
      w2      <= w2_d;
      w3      <= w3_d;
      crc_err <= crc_d;
    end
  end

  a_r10_long_no_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && long_sel) |=> !crc_err);

endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine #(
  parameter int DIV_W   = 8,
  parameter int PWS_W   = 3,
  parameter int NCR_MAX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             pws_en,
  input  logic [PWS_W-1:0] pws_div,
  input  logic             cmd_valid,
  input  logic [5:0]       cmd_index,
  input  logic [31:0]      cmd_arg,
  input  logic [1:0]       rsp_kind,
  input  logic             cmd_od,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             crc_err,
  output logic [31:0]      rsp_w0,
  output logic [31:0]      rsp_w1,
  output logic [31:0]      rsp_w2,
  output logic [31:0]      rsp_w3,
  output logic             mmc_clk,
  output logic             cmd_out,
  output logic             cmd_oe,
  input  logic             cmd_in
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       rise_tick, shift_en, cap_clr, cap_latch, long_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  mmc_clkgen #(.DIV_W(DIV_W), .PWS_W(PWS_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .enable    (enable),
    .bus_idle  (!busy),
    .pws_en    (pws_en),
    .pws_div   (pws_div),
    .clk_div   (clk_div),
    .card_clk  (mmc_clk),
    .rise_tick (rise_tick)
  );

  mmc_cmd_seq #(.NCR_MAX(NCR_MAX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .enable    (enable),
    .rise_tick (rise_tick),
    .cmd_valid (cmd_valid),
    .cmd_index (cmd_index),
    .cmd_arg   (cmd_arg),
    .rsp_kind  (rsp_kind),
    .cmd_od    (cmd_od),
    .cmd_in    (cmd_in),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .cmd_out   (cmd_out),
    .cmd_oe    (cmd_oe),
    .shift_en  (shift_en),
    .cap_clr   (cap_clr),
    .cap_latch (cap_latch),
    .long_sel  (long_sel)
  );

  mmc_rsp_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .shift_en (shift_en),
    .bit_in   (cmd_in),
    .clr      (cap_clr),
    .latch    (cap_latch),
    .long_sel (long_sel),
    .w0       (rsp_w0),
    .w1       (rsp_w1),
    .w2       (rsp_w2),
    .w3       (rsp_w3),
    .crc_err  (crc_err)
  );

endmodule

// File: tb/mmc_cmd_engine_tb.sv
`timescale 1ns/1ps
module mmc_cmd_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, pws_en, cmd_valid, cmd_od, cmd_in;
  logic [7:0]  clk_div;
  logic [2:0]  pws_div;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [1:0]  rsp_kind;
  logic        busy, done, timeout, crc_err, mmc_clk, cmd_out, cmd_oe;
  logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;
  logic        line;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign line = cmd_oe ? cmd_out : 1'b1;

  mmc_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
    .pws_en(pws_en), .pws_div(pws_div), .cmd_valid(cmd_valid),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_kind(rsp_kind),
    .cmd_od(cmd_od), .busy(busy), .done(done), .timeout(timeout),
    .crc_err(crc_err), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_w2(rsp_w2),
    .rsp_w3(rsp_w3), .mmc_clk(mmc_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in)
  );

  always @(negedge clk) if (done) done_cnt++;

  function automatic logic [6:0] ref_crc7(input logic [39:0] m);
    logic [6:0] r = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      if (m[i] ^ r[6]) r = {r[5:0], 1'b0} ^ 7'b0001001;
      else             r = {r[5:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] i, input logic [31:0] a);
    logic [39:0] h = {1'b0, 1'b1, i, a};
    return {h, ref_crc7(h), 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int k = 0; k < 20000 && done_cnt == 0; k++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(output int cyc);
    time t0;
    @(posedge mmc_clk);
    t0 = $time;
    @(posedge mmc_clk);
    cyc = int'(($time - t0) / 10);
  endtask

  // dly: card periods after end-bit fall before the reply start is driven (1..64 valid)
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                         input logic od, input int dly, input logic bad, input logic no_reply);
    logic [47:0]  exp_f, got_f, r48;
    logic [135:0] r136;
    logic [127:0] pay;
    logic [31:0]  rarg;
    logic [39:0]  rh;
    bit           drv_ok, found, has_rsp;
    has_rsp = (kind == 2'd1) || (kind == 2'd2);
    exp_f = ref_frame(idx, arg);
    while (busy) @(negedge clk);
    done_cnt = 0;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; rsp_kind = kind; cmd_od = od; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    found = 0; drv_ok = 1; got_f = '1;
    for (int k = 0; k < 4000 && !found; k++) begin
      @(negedge mmc_clk); #1;
      if (line == 1'b0) found = 1;
    end
    got_f[47] = 1'b0;
    for (int b = 46; b >= 0; b--) begin
      @(negedge mmc_clk); #1;
      got_f[b] = line;
      if (od && cmd_oe && cmd_out) drv_ok = 0;
      if (!od && !cmd_oe) drv_ok = 0;
    end
    check(got_f == exp_f, "R4", "frame bits", 128'(got_f), 128'(exp_f));
    check(drv_ok, "R6", "drive mode per bit", 128'(drv_ok), 128'(1));
    @(negedge mmc_clk); #1;
    check(!cmd_oe, "R6", "wire released after end bit", 128'(cmd_oe), 128'(0));
    r48 = '0; r136 = '0; rarg = $urandom;
    if (has_rsp && !no_reply) begin
      repeat (dly - 1) begin @(negedge mmc_clk); #1; end
      if (kind == 2'd1) begin
        rh  = {2'b00, 6'($urandom), rarg};
        r48 = {rh, ref_crc7(rh), 1'b1};
        if (bad) r48[1] = ~r48[1];
        for (int b = 47; b >= 0; b--) begin
          cmd_in = r48[b]; @(negedge mmc_clk); #1;
        end
      end else begin
        pay  = {$urandom, $urandom, $urandom, $urandom};
        r136 = {8'h3F, pay};
        for (int b = 135; b >= 0; b--) begin
          cmd_in = r136[b]; @(negedge mmc_clk); #1;
        end
      end
      cmd_in = 1'b1;
    end
    wait_done();
    check(done_cnt == 1, "R11", "done pulse width", 128'(done_cnt), 128'(1));
    if (!has_rsp) begin
      check(!timeout && !crc_err, "R7", "no-reply status", 128'({timeout, crc_err}), 128'(0));
    end else if (no_reply) begin
      check(timeout, "R8", "timeout without start bit", 128'(timeout), 128'(1));
    end else if (kind == 2'd1) begin
      check(!timeout, "R8", "start accepted", 128'(timeout), 128'(0));
      check({rsp_w3, rsp_w2, rsp_w1, rsp_w0} == {96'd0, rarg}, "R9", "short payload",
            {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, {96'd0, rarg});
      check(crc_err == bad, "R9", "crc flag", 128'(crc_err), 128'(bad));
    end else begin
      check(!timeout, "R8", "start accepted", 128'(timeout), 128'(0));
      check({rsp_w3, rsp_w2, rsp_w1, rsp_w0} == r136[127:0], "R10", "long payload",
            {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, r136[127:0]);
      check(!crc_err, "R10", "no crc on long", 128'(crc_err), 128'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    int unsigned sd;
    logic [47:0] f0;
    sd = $urandom(32'd91173);
    rst_n = 1'b0; enable = 1'b0; pws_en = 1'b0; pws_div = 3'd0; clk_div = 8'd1;
    cmd_valid = 1'b0; cmd_od = 1'b0; cmd_in = 1'b1; cmd_index = '0; cmd_arg = '0; rsp_kind = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and disabled behaviour
    check(!busy && !done && !cmd_oe && !mmc_clk && !timeout && !crc_err, "R1", "reset outputs",
          128'({busy, done, cmd_oe, mmc_clk, timeout, crc_err}), 128'(0));
    check({rsp_w3, rsp_w2, rsp_w1, rsp_w0} == '0, "R1", "reset response words",
          {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, 128'(0));
    done_cnt = 0;
    cmd_valid = 1'b1; rsp_kind = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (50) @(negedge clk);
    check(!busy && !cmd_oe && !mmc_clk && done_cnt == 0, "R1", "command ignored while disabled",
          128'({busy, cmd_oe, mmc_clk, 1'(done_cnt != 0)}), 128'(0));

    enable = 1'b1;
    // R2: base card clock
    repeat (2) @(posedge mmc_clk);
    measure(cyc);
    check(cyc == 4, "R2", "period clk_div=1", 128'(cyc), 128'(4));
    clk_div = 8'd3;
    repeat (2) @(posedge mmc_clk);
    measure(cyc);
    check(cyc == 8, "R2", "period clk_div=3", 128'(cyc), 128'(8));
    clk_div = 8'd1;
    // R3: idle power-save divide
    pws_en = 1'b1; pws_div = 3'd2;
    repeat (2) @(posedge mmc_clk);
    measure(cyc);
    check(cyc == 32, "R3", "idle period pws_div=2", 128'(cyc), 128'(32));
    pws_div = 3'd0;
    repeat (2) @(posedge mmc_clk);
    measure(cyc);
    check(cyc == 8, "R3", "idle period pws_div=0", 128'(cyc), 128'(8));
    // R3: full rate while busy
    pws_div = 3'd2;
    repeat (2) @(posedge mmc_clk);
    @(negedge clk);
    done_cnt = 0;
    cmd_index = 6'd5; cmd_arg = 32'h0; rsp_kind = 2'd0; cmd_od = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(posedge mmc_clk);
    measure(cyc);
    check(busy && cyc == 4, "R3", "busy period ignores power save", 128'(cyc), 128'(4));
    wait_done();
    pws_en = 1'b0;

    // R5: known CRC for index 0, argument 0
    f0 = ref_frame(6'd0, 32'd0);
    check(f0[7:0] == 8'h95, "R5", "reference crc byte", 128'(f0[7:0]), 128'(8'h95));
    run_cmd(6'd0, 32'd0, 2'd0, 1'b0, 1, 1'b0, 1'b0);
    // R7: code 3 means no reply; R6 open drain
    run_cmd(6'd7, 32'hA5A5_0F0F, 2'd3, 1'b1, 1, 1'b0, 1'b0);
    // R8: earliest and latest start, then timeout
    run_cmd(6'd13, 32'h1234_5678, 2'd1, 1'b0, 1, 1'b0, 1'b0);
    run_cmd(6'd13, 32'h8765_4321, 2'd1, 1'b1, 64, 1'b0, 1'b0);
    run_cmd(6'd17, 32'hFFFF_0000, 2'd1, 1'b0, 1, 1'b0, 1'b1);
    // R11: flags cleared by the next accepted command
    run_cmd(6'd1, 32'h0, 2'd0, 1'b0, 1, 1'b0, 1'b0);
    // R9 bad crc, R10 long reply (broadcast identity request, stuff-bit argument)
    run_cmd(6'd9, 32'hDEAD_BEEF, 2'd1, 1'b0, 3, 1'b1, 1'b0);
    run_cmd(6'd2, 32'h0, 2'd2, 1'b1, 5, 1'b0, 1'b0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      pws_en  = 1'($urandom);
      pws_div = 3'($urandom % 2);
      run_cmd(6'($urandom), $urandom, 2'($urandom % 3), 1'($urandom), 1 + int'($urandom % 64),
              1'($urandom % 4 == 0), 1'($urandom % 8 == 0));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule